// File: doc/BRIEF.md
# Camera Control Register Slave

This block is the register bank of an image sensor that a host reaches over a two-wire serial bus. A separate bit-level engine turns the bus into byte events: start, stop, a received byte, the moment an acknowledge bit has been sent, and a request for a read byte. This block makes the acknowledge decision for each byte and supplies the read data. It holds twenty-one byte-wide control registers, which are also brought out in parallel to the rest of the sensor.

A write transaction carries the device address, one subaddress byte and one data byte. A read transaction carries only the device address and returns the register selected by the subaddress of the most recent write transaction. Three strap pins place the device at one of eight bus addresses. A soft reset bit in a control register returns everything to defaults, but only once the acknowledge bit of that write has gone out. While auto mode is on, an internal auto-control engine owns four registers: gain, the two colour balances and exposure. It updates them through its own port, and bus writes to them are dropped.

Top module: `cam_reg_slave`

## Requirements
- R1: On reset every implemented register takes its default. Those defaults are 0x00:00, 0x01:80, 0x02:80, 0x03:80, 0x04:80, 0x05:00, 0x06:80, 0x07:D4, 0x0C:20, 0x0D:20, 0x0E:14, 0x0F:A5, 0x11:00, 0x12:24, 0x13:01 and 0x14:04. Register 0x10 resets to 7F when `scan_interlaced` is 1 and to FF when it is 0. Register i appears on `reg_bank[8i+7:8i]`.
- R2: The first byte after a start is acknowledged only if it equals 0x42 + 4*`strap_cs` (write) or that value plus one (read). Otherwise it is not acknowledged, and the rest of the transaction is not acknowledged and writes nothing.
- R3: The acknowledge decision for a byte appears on `ack_valid`/`ack` in the cycle after `byte_valid`. In a write, the second byte is stored as the subaddress and the third is written to that register, and both are acknowledged.
- R4: After the data byte, further bytes of the same write are not acknowledged and write nothing. The subaddress does not advance.
- R5: `rd_req` yields `rd_valid` one cycle later, with `rd_data` holding the register at the stored subaddress. A write carrying only a subaddress still sets the pointer.
- R6: Writes to the unimplemented subaddresses 0x08 to 0x0B, or above 0x14, are acknowledged but change nothing. Reads of those subaddresses return 0x00.
- R7: Bits 7:6 of register 0x00 always read 0.
- R8: A write of register 0x12 with bit 7 set restores every register and the subaddress pointer to defaults on the `ack_done` pulse that follows the data byte. Bit 7 of register 0x12 always reads 0.
- R9: While bit 0 of register 0x13 is 1, bus writes to 0x00, 0x01, 0x02 and 0x10 are dropped. During that time `auto_we` writes `auto_data` to the register chosen by `auto_sel` (0 to 0x00, 1 to 0x01, 2 to 0x02, 3 to 0x10), and reads return that value. While the bit is 0, `auto_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_cs | input | 3 | Address strap pins |
| scan_interlaced | input | 1 | Scan mode, selects the exposure default |
| bus_start | input | 1 | Start or repeated start seen (pulse) |
| bus_stop | input | 1 | Stop seen (pulse) |
| byte_valid | input | 1 | A byte has been received (pulse) |
| byte_data | input | 8 | Received byte |
| ack_done | input | 1 | Acknowledge bit of the last byte has been sent (pulse) |
| rd_req | input | 1 | Master requests a read byte (pulse) |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| auto_we | input | 1 | Auto-control write strobe |
| auto_sel | input | 2 | Auto-control target register |
| auto_data | input | 8 | Auto-control value |
| reg_bank | output | 168 | All registers in parallel, register i at bits 8i+7:8i |

## Verification
The soft reset is the hardest case to reach. It needs a matching address, the control subaddress, a data byte with bit 7 set, and then the separate acknowledge-sent pulse. The effect must also be told apart from an ordinary write. The bench splits the data byte from the acknowledge-sent pulse so that it can look at the registers between the two. It changes the scan-mode input first, so the restored exposure default differs from the value loaded at power-up. Auto mode starts enabled, so the ownership checks run before the vector table clears it.

// File: rtl/cam_reg_pkg.sv
package cam_reg_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 21;
  localparam int IDX_W     = $clog2(NUM_REGS);

  localparam logic [7:0] SUB_GAIN  = 8'h00;
  localparam logic [7:0] SUB_CTRLA = 8'h12;
  localparam logic [7:0] SUB_CTRLB = 8'h13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_SUB, ST_DATA, ST_DONE, ST_READ
  } xact_state_t;

  function automatic logic reg_present(input int idx);
    return (idx < 8) || (idx >= 12 && idx < NUM_REGS);
  endfunction

  // Bits that storage keeps for each register.
  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'h3F;
      18:      return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int idx, input logic interlaced);
    case (idx)
      1, 2, 3, 4, 6: return 8'h80;
      7:             return 8'hD4;
      12, 13:        return 8'h20;
      14:            return 8'h14;
      15:            return 8'hA5;
      16:            return interlaced ? 8'h7F : 8'hFF;
      18:            return 8'h24;
      19:            return 8'h01;
      20:            return 8'h04;
      default:       return 8'h00;
    endcase
  endfunction

  // Auto-control ownership: returns the selector, or -1 if not owned.
  function automatic int auto_slot(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      16:      return 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/cam_dev_match.sv
module cam_dev_match #(
  parameter int         CS_W  = 3,
  parameter logic [5-CS_W:0] ID_HI = 3'b010
) (
  input  logic [CS_W-1:0] strap_cs,
  input  logic [7:0]      addr_byte,
  output logic            hit,
  output logic            is_read
);
  logic [6:0] own_id;
  assign own_id  = {ID_HI, strap_cs, 1'b1};
  assign hit     = (addr_byte[7:1] == own_id);
  assign is_read = addr_byte[0];
endmodule

// File: rtl/cam_xact_fsm.sv
module cam_xact_fsm
  import cam_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       ack_done,
  input  logic       dev_hit,
  input  logic       dev_rd,
  output logic       ack_valid,
  output logic       ack,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] sub_ptr,
  output logic       soft_rst
);
  xact_state_t state;
  logic        pend;

  assign wr_en    = byte_valid && (state == ST_DATA);
  assign wr_data  = byte_data;
  assign soft_rst = pend && ack_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      sub_ptr   <= '0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= byte_valid;
      if (soft_rst) begin
        pend    <= 1'b0;
        sub_ptr <= '0;
      end
      if (bus_start) begin
        state <= ST_DEV;
        pend  <= 1'b0;
      end else if (bus_stop) begin
        state <= ST_IDLE;
      end else if (byte_valid) begin
        case (state)
          ST_DEV: begin
            ack   <= dev_hit;
            state <= !dev_hit ? ST_DONE : (dev_rd ? ST_READ : ST_SUB);
          end
          ST_SUB: begin
            ack     <= 1'b1;
            sub_ptr <= byte_data;
            state   <= ST_DATA;
          end
          ST_DATA: begin
            ack   <= 1'b1;
            pend  <= (sub_ptr == SUB_CTRLA) && byte_data[7];
            state <= ST_DONE;
          end
          default: ack <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_reg_file.sv
module cam_reg_file
  import cam_reg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      soft_rst,
  input  logic                      interlaced,
  input  logic                      wr_en,
  input  logic [7:0]                wr_sub,
  input  logic [7:0]                wr_data,
  input  logic                      auto_we,
  input  logic [1:0]                auto_sel,
  input  logic [7:0]                auto_data,
  input  logic                      rd_req,
  output logic [NUM_REGS*REG_W-1:0] reg_bank,
  output logic                      rd_valid,
  output logic [7:0]                rd_data
);
  logic [REG_W-1:0] q [NUM_REGS];
  logic             auto_mode;

  assign auto_mode = q[SUB_CTRLB][0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (reg_present(i)) begin : g_impl
      localparam int SLOT = auto_slot(i);
      logic owned, bus_hit, auto_hit;
      if (SLOT >= 0) begin : g_own
        assign owned    = auto_mode;
        assign auto_hit = auto_mode && auto_we && (auto_sel == 2'(SLOT));
      end else begin : g_free
        assign owned    = 1'b0;
        assign auto_hit = 1'b0;
      end
      assign bus_hit = wr_en && (wr_sub == 8'(i)) && !owned;
      always_ff @(posedge clk) begin
        if (rst || soft_rst)
          q[i] <= reg_default(i, interlaced);
        else if (auto_hit)
          q[i] <= auto_data & reg_mask(i);
        else if (bus_hit)
          q[i] <= wr_data & reg_mask(i);
      end
    end else begin : g_hole
      assign q[i] = '0;
    end
    assign reg_bank[i*REG_W +: REG_W] = q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= (wr_sub < 8'(NUM_REGS)) ? q[wr_sub[IDX_W-1:0]] : '0;
    end
  end
endmodule

// File: rtl/cam_reg_slave.sv
module cam_reg_slave
  import cam_reg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                strap_cs,
  input  logic                      scan_interlaced,
  input  logic                      bus_start,
  input  logic                      bus_stop,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic                      ack_done,
  input  logic                      rd_req,
  output logic                      ack_valid,
  output logic                      ack,
  output logic                      rd_valid,
  output logic [7:0]                rd_data,
  input  logic                      auto_we,
  input  logic [1:0]                auto_sel,
  input  logic [7:0]                auto_data,
  output logic [NUM_REGS*REG_W-1:0] reg_bank
);
  logic       dev_hit, dev_rd, wr_en, soft_rst;
  logic [7:0] wr_data, sub_ptr;

  cam_dev_match #(.CS_W(3), .ID_HI(3'b010)) u_match (
    .strap_cs (strap_cs),
    .addr_byte(byte_data),
    .hit      (dev_hit),
    .is_read  (dev_rd)
  );

  cam_xact_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .ack_done  (ack_done),
    .dev_hit   (dev_hit),
    .dev_rd    (dev_rd),
    .ack_valid (ack_valid),
    .ack       (ack),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sub_ptr   (sub_ptr),
    .soft_rst  (soft_rst)
  );

  cam_reg_file u_regs (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .interlaced(scan_interlaced),
    .wr_en     (wr_en),
    .wr_sub    (sub_ptr),
    .wr_data   (wr_data),
    .auto_we   (auto_we),
    .auto_sel  (auto_sel),
    .auto_data (auto_data),
    .rd_req    (rd_req),
    .reg_bank  (reg_bank),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/cam_reg_slave_chk.sv
module cam_reg_slave_chk
  import cam_reg_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic                      byte_valid,
  input logic                      ack_valid,
  input logic                      rd_req,
  input logic                      rd_valid,
  input logic                      auto_we,
  input logic                      ack_done,
  input logic [NUM_REGS*REG_W-1:0] reg_bank
);
  a_r3_ack_follows_byte: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> ack_valid);

  a_r3_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(byte_valid));

  a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  a_r7_gain_top_zero: assert property (@(posedge clk) disable iff (rst)
    reg_bank[7:6] == 2'b00);

  a_r8_reset_bit_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !reg_bank[SUB_CTRLA*REG_W + 7]);

  a_r9_gain_locked: assert property (@(posedge clk) disable iff (rst)
    (reg_bank[SUB_CTRLB*REG_W] && !auto_we && !ack_done) |=> $stable(reg_bank[7:0]));
endmodule

bind cam_reg_slave cam_reg_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .byte_valid(byte_valid),
  .ack_valid (ack_valid),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .auto_we   (auto_we),
  .ack_done  (ack_done),
  .reg_bank  (reg_bank)
);

// File: tb/tb_cam_reg_slave.sv
module tb_cam_reg_slave;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   strap_cs = 3'd0;
  logic         scan_interlaced = 1'b1;
  logic         bus_start = 0, bus_stop = 0, byte_valid = 0, ack_done = 0, rd_req = 0;
  logic [7:0]   byte_data = 0;
  logic         auto_we = 0;
  logic [1:0]   auto_sel = 0;
  logic [7:0]   auto_data = 0;
  logic         ack_valid, ack, rd_valid;
  logic [7:0]   rd_data;
  logic [167:0] reg_bank;

  int nchk = 0, nfail = 0, cycles = 0;

  always #4 clk = ~clk;

  cam_reg_slave dut (
    .clk(clk), .rst(rst), .strap_cs(strap_cs), .scan_interlaced(scan_interlaced),
    .bus_start(bus_start), .bus_stop(bus_stop), .byte_valid(byte_valid),
    .byte_data(byte_data), .ack_done(ack_done), .rd_req(rd_req),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .auto_we(auto_we), .auto_sel(auto_sel), .auto_data(auto_data), .reg_bank(reg_bank)
  );

  // {subaddress, write data, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    {8'h13, 8'h00, 8'h00},   // R9 leave auto mode
    {8'h03, 8'h5A, 8'h5A},   // R3
    {8'h00, 8'hFF, 8'h3F},   // R7
    {8'h09, 8'h77, 8'h00},   // R6
    {8'h14, 8'hC3, 8'hC3},   // R3
    {8'h0E, 8'h01, 8'h01},   // R3
    {8'h10, 8'h33, 8'h33},   // R9 unlocked
    {8'h04, 8'hE1, 8'hE1},   // R3
    {8'h0B, 8'h12, 8'h00},   // R6
    {8'h1F, 8'hAA, 8'h00}    // R6
  };

  // {index, default} with scan_interlaced = 1
  localparam logic [15:0] DEFS [16] = '{
    {8'h00,8'h00},{8'h01,8'h80},{8'h02,8'h80},{8'h03,8'h80},
    {8'h04,8'h80},{8'h05,8'h00},{8'h06,8'h80},{8'h07,8'hD4},
    {8'h0C,8'h20},{8'h0D,8'h20},{8'h0E,8'h14},{8'h0F,8'hA5},
    {8'h10,8'h7F},{8'h11,8'h00},{8'h12,8'h24},{8'h13,8'h01}
  };

  function automatic logic [7:0] rb(input int idx);
    return reg_bank[idx*8 +: 8];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1; @(negedge clk) bus_start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1; @(negedge clk) bus_stop = 0;
  endtask
  task automatic pulse_ackdone();
    @(negedge clk) ack_done = 1; @(negedge clk) ack_done = 0;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic a, output logic v);
    @(negedge clk) begin byte_valid = 1; byte_data = b; end
    @(negedge clk) byte_valid = 0;
    v = ack_valid; a = ack;
  endtask
  task automatic bus_write(input logic [7:0] dev, input logic [7:0] sub, input logic [7:0] d,
                           output logic [2:0] acks);
    logic v;
    pulse_start();
    send_byte(dev, acks[2], v); pulse_ackdone();
    send_byte(sub, acks[1], v); pulse_ackdone();
    send_byte(d,   acks[0], v); pulse_ackdone();
    pulse_stop();
  endtask
  task automatic bus_read(input logic [7:0] dev, output logic [7:0] d, output logic a);
    logic v;
    pulse_start();
    send_byte(dev, a, v); pulse_ackdone();
    @(negedge clk) rd_req = 1; @(negedge clk) rd_req = 0;
    d = rd_data;
    pulse_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nchk++; nfail++;
      $display("FAIL watchdog all-reqs actual=%0d expected=<50000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a, v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset defaults
    foreach (DEFS[k])
      check(rb(DEFS[k][15:8]) == DEFS[k][7:0], "R1 default", rb(DEFS[k][15:8]), DEFS[k][7:0]);
    check(rb(20) == 8'h04, "R1 default 0x14", rb(20), 8'h04);
    check(!ack_valid && !rd_valid, "R1 idle outputs", {6'b0, ack_valid, rd_valid}, 8'h00);

    // R9 auto mode on after reset: bus write dropped, auto port owns
    bus_write(8'h42, 8'h01, 8'h11, acks);
    bus_read(8'h43, d, a);
    check(d == 8'h80, "R9 bus write locked", d, 8'h80);
    @(negedge clk) begin auto_we = 1; auto_sel = 2'd1; auto_data = 8'h9C; end
    @(negedge clk) auto_we = 0;
    check(rb(1) == 8'h9C, "R9 auto write", rb(1), 8'h9C);
    bus_read(8'h43, d, a);
    check(d == 8'h9C, "R9 read auto value", d, 8'h9C);
    @(negedge clk) begin auto_we = 1; auto_sel = 2'd3; auto_data = 8'h21; end
    @(negedge clk) auto_we = 0;
    check(rb(16) == 8'h21, "R9 auto exposure", rb(16), 8'h21);

    // Vector table
    foreach (VEC[k]) begin
      bus_write(8'h42, VEC[k][23:16], VEC[k][15:8], acks);
      check(acks == 3'b111, "R3 write acks", {5'b0, acks}, 8'h07);
      bus_read(8'h43, d, a);
      check(a && d == VEC[k][7:0], "R5/R6 read back", d, VEC[k][7:0]);
    end

    // R9 auto port ignored when auto mode off
    @(negedge clk) begin auto_we = 1; auto_sel = 2'd2; auto_data = 8'h0F; end
    @(negedge clk) auto_we = 0;
    check(rb(2) == 8'h80, "R9 auto ignored off", rb(2), 8'h80);

    // R2 wrong address ignored
    bus_write(8'h46, 8'h03, 8'h00, acks);
    check(acks == 3'b000, "R2 wrong address nack", {5'b0, acks}, 8'h00);
    check(rb(3) == 8'h5A, "R2 no write", rb(3), 8'h5A);
    strap_cs = 3'd5;
    bus_write(8'h56, 8'h05, 8'h6B, acks);
    check(acks == 3'b111, "R2 strapped address", {5'b0, acks}, 8'h07);
    bus_read(8'h57, d, a);
    check(a && d == 8'h6B, "R2 strapped read", d, 8'h6B);
    bus_read(8'h43, d, a);
    check(!a, "R2 old read address nack", {7'b0, a}, 8'h00);

    // R4 extra byte nacked, no increment
    pulse_start();
    send_byte(8'h56, a, v); pulse_ackdone();
    send_byte(8'h06, a, v); pulse_ackdone();
    send_byte(8'h11, a, v); pulse_ackdone();
    send_byte(8'h22, a, v);
    check(v && !a, "R4 extra byte nack", {6'b0, v, a}, 8'h02);
    pulse_ackdone(); pulse_stop();
    check(rb(6) == 8'h11 && rb(7) == 8'hD4, "R4 no increment", rb(7), 8'hD4);

    // R5 subaddress-only write sets pointer
    pulse_start();
    send_byte(8'h56, a, v); pulse_ackdone();
    send_byte(8'h0D, a, v); pulse_ackdone();
    pulse_stop();
    bus_read(8'h57, d, a);
    check(d == 8'h20, "R5 pointer only", d, 8'h20);
    @(negedge clk) rd_req = 1; @(negedge clk) rd_req = 0;
    check(rd_valid && rd_data == 8'h20, "R5 repeat read", rd_data, 8'h20);

    // R8 soft reset after ack
    scan_interlaced = 1'b0;
    pulse_start();
    send_byte(8'h56, a, v); pulse_ackdone();
    send_byte(8'h12, a, v); pulse_ackdone();
    send_byte(8'h85, a, v);
    check(rb(18) == 8'h05, "R8 bit7 reads zero", rb(18), 8'h05);
    check(rb(3) == 8'h5A, "R8 not before ack", rb(3), 8'h5A);
    pulse_ackdone();
    check(rb(3) == 8'h80, "R8 defaults restored", rb(3), 8'h80);
    check(rb(16) == 8'hFF, "R8 progressive exposure", rb(16), 8'hFF);
    check(rb(18) == 8'h24 && rb(19) == 8'h01, "R8 control defaults", rb(18), 8'h24);
    pulse_stop();
    bus_read(8'h57, d, a);
    check(d == 8'h00, "R8 pointer reset", d, 8'h00);

    finish_run();
  end
endmodule